// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block is the byte-wide register bank behind the control port of a data-converter-style peripheral. A host writes it and reads it through a plain parallel interface with an address, write data, a write strobe, a read strobe and read data. The registers that drive the datapath are double-buffered. A write to one of them changes only its staged copy. All staged copies move to their live copies together when the host sets the commit bit in the update register.

A few control addresses bypass the staging and act at once: the port-configuration register, two direct control registers and the update register itself. Two addresses are fixed identification values that ignore writes. Reads never depend on a commit. A read of a buffered address returns the live copy. A read of an address that is not implemented returns zero. The live values leave the block as parallel output buses.

Top module: `cfg_regbank`

## Requirements
- R1: After reset the live buffered registers hold 0x08=0x00, 0x10=0x00, 0x11=0x06 (gain) and 0x14=0x03. port_cfg is 0x18, where bit 6 is the LSB-first select and 0 means MSB-first. The direct registers 0x04 and 0x05 hold 0x0F and 0x00.
- R2: A write to a buffered address (0x08, 0x10, 0x11, 0x14) changes only its staged copy. act_regs and read data for that address keep the old live value until a commit.
- R3: A write of a value with bit 0 set to address 0xFF copies every staged copy to its live copy at that clock edge. act_regs shows the new values from the next cycle. act_regs packs the register at 0x08 in bits 7:0, 0x10 in 15:8, 0x11 in 23:16 and 0x14 in 31:24.
- R4: The commit bit reads as 1 (read data 0x01 at 0xFF) when read in the cycle right after the commit write. It has cleared itself by the cycle after that and reads 0x00.
- R5: A write to 0x00, 0x04 or 0x05 takes effect on the outputs from the next cycle with no commit. imm_regs packs 0x04 in bits 7:0 and 0x05 in 15:8.
- R6: Address 0x01 reads 0x2F, and writes to it are ignored.
- R7: Address 0x02 reads 0x20 (bits 5:4 = 2'b10), and writes to it are ignored.
- R8: rd_data updates on the clock edge at which rd_en is sampled high, so the value is available one cycle after the request. It holds its value while rd_en is low.
- R9: An unimplemented address reads 0x00, and a write to it changes no register and no output.
- R10: A write to 0xFF with bit 0 clear commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| act_regs | output | 32 | Live copies of the four buffered registers |
| port_cfg | output | 8 | Port-configuration register (0x00) |
| imm_regs | output | 16 | Direct registers 0x04 and 0x05 |

## Verification
A write to a direct address or a commit lands on the output buses at the edge that samples the strobe. The bench therefore drives each access for exactly one cycle from a falling edge and checks the buses at the next falling edge. Read data is registered once, so a read task raises rd_en for one cycle and captures rd_data at the following falling edge. That timing places a read issued right after a commit in the only cycle where the commit bit still shows 1. A second read confirms that the bit has cleared.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int NUM_BUF = 4;
  localparam int NUM_IMM = 2;

  localparam logic [ADDR_W-1:0] ADR_PORT  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_ID    = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_GRADE = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_XFER  = 8'hFF;

  localparam logic [DATA_W-1:0] ID_VALUE    = 8'h2F;
  localparam logic [DATA_W-1:0] GRADE_VALUE = 8'h20;
  localparam logic [DATA_W-1:0] PORT_RESET  = 8'h18;

  function automatic logic [ADDR_W-1:0] buf_addr(input int i);
    case (i)
      0: return 8'h08;
      1: return 8'h10;
      2: return 8'h11;
      default: return 8'h14;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] buf_reset(input int i);
    case (i)
      2: return 8'h06;
      3: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] imm_addr(input int i);
    return (i == 0) ? 8'h04 : 8'h05;
  endfunction

  function automatic logic [DATA_W-1:0] imm_reset(input int i);
    return (i == 0) ? 8'h0F : 8'h00;
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = (a == ADR_PORT) || (a == ADR_ID) || (a == ADR_GRADE) || (a == ADR_XFER);
    for (int i = 0; i < NUM_BUF; i++) hit = hit || (a == buf_addr(i));
    for (int i = 0; i < NUM_IMM; i++) hit = hit || (a == imm_addr(i));
    return hit;
  endfunction
endpackage

// File: rtl/cfg_write_decode.sv
module cfg_write_decode
  import cfg_regbank_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_BUF-1:0] buf_hit,
  output logic [NUM_IMM-1:0] imm_hit,
  output logic              port_hit,
  output logic              commit
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    assign buf_hit[i] = wr_en && (addr == buf_addr(i));
  end
  for (genvar i = 0; i < NUM_IMM; i++) begin : g_imm
    assign imm_hit[i] = wr_en && (addr == imm_addr(i));
  end
  assign port_hit = wr_en && (addr == ADR_PORT);
  assign commit   = wr_en && (addr == ADR_XFER) && wdata[0];
endmodule

// File: rtl/cfg_shadow_pair.sv
module cfg_shadow_pair
  import cfg_regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  output logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= RST;
      act  <= RST;
    end else begin
      if (wr_hit) pend <= wdata;
      if (commit) act  <= pend;
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_BUF*DATA_W-1:0] act_flat,
  input  logic [NUM_IMM*DATA_W-1:0] imm_flat,
  input  logic [DATA_W-1:0]         port_val,
  input  logic                      xfer_bit,
  output logic [DATA_W-1:0]         value
);
  always_comb begin
    value = '0;
    if (addr == ADR_PORT)       value = port_val;
    else if (addr == ADR_ID)    value = ID_VALUE;
    else if (addr == ADR_GRADE) value = GRADE_VALUE;
    else if (addr == ADR_XFER)  value = {{(DATA_W-1){1'b0}}, xfer_bit};
    else begin
      for (int i = 0; i < NUM_BUF; i++)
        if (addr == buf_addr(i)) value = act_flat[i*DATA_W +: DATA_W];
      for (int i = 0; i < NUM_IMM; i++)
        if (addr == imm_addr(i)) value = imm_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_BUF*DATA_W-1:0] act_regs,
  output logic [DATA_W-1:0]         port_cfg,
  output logic [NUM_IMM*DATA_W-1:0] imm_regs
);
  logic [NUM_BUF-1:0]        buf_hit;
  logic [NUM_IMM-1:0]        imm_hit;
  logic                      port_hit;
  logic                      commit;
  logic                      xfer_q;
  logic [NUM_BUF*DATA_W-1:0] pend_flat;
  logic [DATA_W-1:0]         rd_next;

  cfg_write_decode u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .buf_hit(buf_hit), .imm_hit(imm_hit), .port_hit(port_hit), .commit(commit)
  );

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_pair
    cfg_shadow_pair #(.RST(buf_reset(i))) u_pair (
      .clk(clk), .rst_n(rst_n), .wr_hit(buf_hit[i]), .wdata(wdata), .commit(commit),
      .pend(pend_flat[i*DATA_W +: DATA_W]), .act(act_regs[i*DATA_W +: DATA_W])
    );
  end

  for (genvar i = 0; i < NUM_IMM; i++) begin : g_imm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          imm_regs[i*DATA_W +: DATA_W] <= imm_reset(i);
      else if (imm_hit[i]) imm_regs[i*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_cfg <= PORT_RESET;
      xfer_q   <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (port_hit) port_cfg <= wdata;
      xfer_q <= commit;
      if (rd_en) rd_data <= rd_next;
    end
  end

  cfg_read_mux u_rmux (
    .addr(addr), .act_flat(act_regs), .imm_flat(imm_regs),
    .port_val(port_cfg), .xfer_bit(xfer_q), .value(rd_next)
  );
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk
  import cfg_regbank_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wdata,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_BUF*DATA_W-1:0] act_regs,
  input logic [NUM_BUF*DATA_W-1:0] pend_flat,
  input logic [NUM_IMM*DATA_W-1:0] imm_regs,
  input logic                      commit
);
  a_r2_live_held: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_regs));
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_XFER && wdata[0]) |=> act_regs == $past(pend_flat));
  a_r5_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == imm_addr(1)) |=> imm_regs[2*DATA_W-1:DATA_W] == $past(wdata));
  a_r6_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_ID) |=> rd_data == ID_VALUE);
  a_r7_grade_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADR_GRADE) |=> rd_data[5:4] == 2'b10);
  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_mapped(addr)) |=> rd_data == '0);
endmodule

bind cfg_regbank cfg_regbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rd_data(rd_data), .act_regs(act_regs), .pend_flat(pend_flat), .imm_regs(imm_regs),
  .commit(commit)
);

// File: tb/cfg_regbank_tb_top.sv
module cfg_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rd_data, port_cfg;
  logic [31:0] act_regs;
  logic [15:0] imm_regs;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .act_regs(act_regs), .port_cfg(port_cfg), .imm_regs(imm_regs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 act_regs", act_regs, 32'h0306_0000);
    check("R1 port_cfg", port_cfg, 32'h18);
    check("R1 imm_regs", imm_regs, 32'h000F);
    rd(8'h11, d); check("R1 gain read", d, 32'h06);
  endtask

  task automatic t_buffered;
    logic [7:0] d;
    wr(8'h08, 8'hA1); wr(8'h11, 8'h5C);
    check("R2 act unchanged", act_regs, 32'h0306_0000);
    rd(8'h11, d); check("R2 read live copy", d, 32'h06);
    wr(8'hFF, 8'h00);
    check("R10 no commit on bit0=0", act_regs, 32'h0306_0000);
    wr(8'hFF, 8'h01);
    check("R3 commit applied", act_regs, 32'h035C_00A1);
    rd(8'hFF, d); check("R4 commit bit set", d, 32'h01);
    rd(8'hFF, d); check("R4 commit bit cleared", d, 32'h00);
    rd(8'h08, d); check("R3 read after commit", d, 32'hA1);
  endtask

  task automatic t_direct;
    wr(8'h04, 8'h77);
    check("R5 imm 0x04", imm_regs, 32'h0077);
    wr(8'h05, 8'hC3);
    check("R5 imm 0x05", imm_regs, 32'hC377);
    wr(8'h00, 8'h40);
    check("R5 port_cfg", port_cfg, 32'h40);
  endtask

  task automatic t_readonly;
    logic [7:0] d;
    wr(8'h01, 8'h00); rd(8'h01, d); check("R6 id", d, 32'h2F);
    wr(8'h02, 8'hFF); rd(8'h02, d); check("R7 grade", d, 32'h20);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(8'h33, 8'h99); wr(8'hFF, 8'h01);
    check("R9 act untouched", act_regs, 32'h035C_00A1);
    check("R9 imm untouched", imm_regs, 32'hC377);
    rd(8'h33, d); check("R9 unmapped read", d, 32'h00);
    addr = 8'h01; @(negedge clk);
    check("R8 hold without rd_en", rd_data, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_buffered();
    t_direct();
    t_readonly();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hang expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule